// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Compare

This block is a 32-bit integer arithmetic and logic unit. It is assembled from a row of identical one-bit slices. Each slice holds an AND gate, an OR gate and a full adder. A shared two-bit select picks what the slice passes out: the AND, the OR, the adder sum, or a "less" input. Carries ripple from the lowest slice to the highest.

Subtraction reuses the adder. One invert line flips every bit of the second operand and also drives the carry into bit 0, so the slices compute a + ~b + 1. The signed less-than compare runs that subtraction. It takes the sign of the true difference, which is the top sum bit corrected by the overflow flag, and routes it back into the less input of bit 0. Every other slice has its less input tied low.

The operation code, the operands and the flags are sampled on the rising clock edge. The result, zero, overflow and carry-out outputs are registered, so they appear one cycle after the inputs. A synchronous active-high reset clears them.

Top module: `alu_sliced`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs are loaded with `result` = 0, `zero` = 1, `overflow` = 0 and `carry_out` = 0.
- R2: Code 3'b000 yields the bitwise AND of `a` and `b`, and code 3'b001 yields the bitwise OR. Every result appears on the outputs at the rising edge that follows the edge where the inputs were sampled.
- R3: Code 3'b010 yields `a + b` modulo 2^32, and `carry_out` is the carry leaving bit 31 of that sum.
- R4: Code 3'b110 yields `a - b` modulo 2^32, computed as a + ~b + 1. `carry_out` is the carry leaving bit 31 of that sum, so it is 1 exactly when `a >= b` unsigned.
- R5: Code 3'b111 yields 1 in bit 0 when `a < b` as signed two's-complement numbers and 0 otherwise, with bits 31..1 at 0. This holds even when the internal subtraction overflows.
- R6: `zero` is 1 exactly when all 32 bits of the registered `result` are 0, so subtracting equal operands raises it.
- R7: For add, `overflow` is 1 exactly when both operands have the same sign and the sign of the sum differs from it; adding operands of opposite sign never overflows. For subtract, `overflow` is 1 exactly when the operand signs differ and the sign of the difference equals the sign of `b`.
- R8: `overflow` is 0 for codes 3'b000, 3'b001 and 3'b111.
- R9: Codes 3'b011, 3'b100 and 3'b101 yield `result` = 0, `zero` = 1 and `overflow` = 0, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| op | input | 3 | Operation code |
| result | output | 32 | Registered result |
| zero | output | 1 | Registered flag, 1 when result is all zeros |
| overflow | output | 1 | Registered signed overflow flag for add and subtract |
| carry_out | output | 1 | Registered carry leaving the top slice (valid for add and subtract) |

## Verification
The hardest case to reach is a signed compare whose internal subtraction overflows. There the raw top sum bit gives the wrong answer, and only the overflow correction on the feedback path into bit 0 makes the result right. Random operands rarely hit this case. The stimulus therefore pairs the most positive and most negative values with small operands of the opposite sign, so the wrong-sign case appears in both directions. Unused operation codes are driven with operands whose AND, OR and sum are all nonzero. This shows at the ports that a zero result comes from the code itself.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  typedef struct packed {
    logic       b_flip;
    slice_sel_e sel;
    logic       ovf_en;
    logic       kill;
  } alu_ctrl_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [2:0] op,
  output alu_ctrl_t  ctrl
);
  always_comb begin
    ctrl.b_flip = 1'b0;
    ctrl.sel    = SEL_AND;
    ctrl.ovf_en = 1'b0;
    ctrl.kill   = 1'b0;
    case (op)
      OP_AND: ctrl.sel = SEL_AND;
      OP_OR:  ctrl.sel = SEL_OR;
      OP_ADD: begin
        ctrl.sel    = SEL_SUM;
        ctrl.ovf_en = 1'b1;
      end
      OP_SUB: begin
        ctrl.b_flip = 1'b1;
        ctrl.sel    = SEL_SUM;
        ctrl.ovf_en = 1'b1;
      end
      OP_SLT: begin
        ctrl.b_flip = 1'b1;
        ctrl.sel    = SEL_LESS;
      end
      default: ctrl.kill = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       b_flip,
  input  logic       c_in,
  input  logic       less,
  input  slice_sel_e sel,
  output logic       r_bit,
  output logic       c_out
);
  logic b_eff;
  logic s_bit;

  assign b_eff = b_bit ^ b_flip;
  assign s_bit = a_bit ^ b_eff ^ c_in;
  assign c_out = (a_bit & b_eff) | (a_bit & c_in) | (b_eff & c_in);

  always_comb begin
    case (sel)
      SEL_AND:  r_bit = a_bit & b_eff;
      SEL_OR:   r_bit = a_bit | b_eff;
      SEL_SUM:  r_bit = s_bit;
      SEL_LESS: r_bit = less;
      default:  r_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_chain.sv
module alu_chain
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             b_flip,
  input  slice_sel_e       sel,
  output logic [WIDTH-1:0] res,
  output logic             c_top,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic carry [0:WIDTH];
  logic top_sum;
  logic set_sig;

  assign carry[0] = b_flip;

  // The true sign of a - b: top sum bit corrected when the subtraction overflows.
  assign top_sum = a[MSB] ^ b[MSB] ^ b_flip ^ carry[MSB];
  assign ovf     = carry[WIDTH] ^ carry[MSB];
  assign set_sig = top_sum ^ ovf;
  assign c_top   = carry[WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic less_in;
    if (i == 0) begin : g_lsb
      assign less_in = set_sig;
    end else begin : g_upper
      assign less_in = 1'b0;
    end
    alu_slice u_slice (
      .a_bit  (a[i]),
      .b_bit  (b[i]),
      .b_flip (b_flip),
      .c_in   (carry[i]),
      .less   (less_in),
      .sel    (sel),
      .r_bit  (res[i]),
      .c_out  (carry[i+1])
    );
  end
endmodule

// File: rtl/alu_sliced.sv
module alu_sliced
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [2:0]       op,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carry_out
);
  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] chain_res;
  logic [WIDTH-1:0] next_res;
  logic             chain_c;
  logic             chain_ovf;

  alu_ctrl u_ctrl (
    .op   (op),
    .ctrl (ctrl)
  );

  alu_chain #(.WIDTH(WIDTH)) u_chain (
    .a      (a),
    .b      (b),
    .b_flip (ctrl.b_flip),
    .sel    (ctrl.sel),
    .res    (chain_res),
    .c_top  (chain_c),
    .ovf    (chain_ovf)
  );

  assign next_res = ctrl.kill ? '0 : chain_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      zero      <= 1'b1;
      overflow  <= 1'b0;
      carry_out <= 1'b0;
    end else begin
      result    <= next_res;
      zero      <= ~|next_res;
      overflow  <= chain_ovf & ctrl.ovf_en;
      carry_out <= chain_c;
    end
  end

  // R2: AND is the bitwise AND of the operands one cycle earlier
  assert_and_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_AND) |-> (result == ($past(a) & $past(b))));

  // R5: the signed compare fills bit 0 only, with the signed comparison
  assert_slt_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_SLT) |->
      (result == {{(WIDTH-1){1'b0}}, ($signed($past(a)) < $signed($past(b)))}));

  // R6: the zero flag tracks the registered result
  assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0));

  // R7: adding operands of opposite sign never overflows
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_ADD && ($past(a[MSB]) != $past(b[MSB]))) |-> !overflow);

  // R7: subtract with differing signs and result sign equal to b's sign overflows
  assert_sub_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == OP_SUB && ($past(a[MSB]) != $past(b[MSB]))
      && (result[MSB] == $past(b[MSB]))) |-> overflow);

  // R8: logic and compare codes never flag overflow
  assert_quiet_ovf_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op) == OP_AND || $past(op) == OP_OR || $past(op) == OP_SLT))
      |-> !overflow);

  // R9: unused codes give an all-zero result and no overflow
  assert_unused_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op) == 3'b011 || $past(op) == 3'b100 || $past(op) == 3'b101))
      |-> (result == '0 && zero && !overflow));
endmodule

// File: tb/tb_alu_sliced.sv
`timescale 1ns/1ps
module tb_alu_sliced;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         zf;
    logic         of;
    logic         co;
    logic         co_valid;
    string        tag;
    string        of_tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [2:0]   op = 3'b000;
  logic [W-1:0] result;
  logic         zero, overflow, carry_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  exp_t sb[$];

  always #4 clk = ~clk;

  alu_sliced #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .a(a), .b(b), .op(op),
    .result(result), .zero(zero), .overflow(overflow), .carry_out(carry_out)
  );

  function automatic exp_t model(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] o);
    exp_t e;
    logic [W:0] s;
    e.of = 1'b0; e.co = 1'b0; e.co_valid = 1'b0; e.of_tag = "R8";
    case (o)
      3'b000: begin e.res = x & y; e.tag = "R2"; end
      3'b001: begin e.res = x | y; e.tag = "R2"; end
      3'b010: begin
        s = {1'b0, x} + {1'b0, y};
        e.res = s[W-1:0]; e.co = s[W]; e.co_valid = 1'b1; e.tag = "R3"; e.of_tag = "R7";
        e.of = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
      end
      3'b110: begin
        s = {1'b0, x} + {1'b0, ~y} + 1;
        e.res = s[W-1:0]; e.co = s[W]; e.co_valid = 1'b1; e.tag = "R4"; e.of_tag = "R7";
        e.of = (x[W-1] != y[W-1]) && (s[W-1] == y[W-1]);
      end
      3'b111: begin
        e.res = {{(W-1){1'b0}}, ($signed(x) < $signed(y))}; e.tag = "R5";
      end
      default: begin e.res = '0; e.tag = "R9"; e.of_tag = "R9"; end
    endcase
    e.zf = (e.res == '0);
    return e;
  endfunction

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic [2:0] o);
    @(negedge clk);
    a = x; b = y; op = o;
    sb.push_back(model(x, y, o));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "result", result, e.res);
        check("R6", "zero", {31'd0, zero}, {31'd0, e.zf});
        check(e.of_tag, "overflow", {31'd0, overflow}, {31'd0, e.of});
        if (e.co_valid) check(e.tag, "carry_out", {31'd0, carry_out}, {31'd0, e.co});
      end
    end
  end

  initial begin
    #160000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset result", result, '0);
    check("R1", "reset zero", {31'd0, zero}, 32'd1);
    check("R1", "reset overflow", {31'd0, overflow}, 32'd0);
    check("R1", "reset carry", {31'd0, carry_out}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R2 logic
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 3'b000);
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 3'b001);
    drive(32'hAAAA_AAAA, 32'h5555_5555, 3'b000);
    // R3 add: plain, carry out, overflow both signs, mixed signs
    drive(32'd1000, 32'd2345, 3'b010);
    drive(32'hFFFF_FFFF, 32'd1, 3'b010);
    drive(32'h7FFF_FFFF, 32'd1, 3'b010);
    drive(32'h8000_0000, 32'h8000_0000, 3'b010);
    drive(32'h7FFF_FFFF, 32'h8000_0000, 3'b010);
    // R4 subtract: equal (zero), borrow, overflow cases
    drive(32'h1234_5678, 32'h1234_5678, 3'b110);
    drive(32'd5, 32'd9, 3'b110);
    drive(32'h8000_0000, 32'd1, 3'b110);
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
    // R5 compare, including overflowing differences
    drive(32'hFFFF_FFFF, 32'd1, 3'b111);
    drive(32'd1, 32'hFFFF_FFFF, 3'b111);
    drive(32'h8000_0000, 32'd1, 3'b111);
    drive(32'h7FFF_FFFF, 32'h8000_0000, 3'b111);
    drive(32'd42, 32'd42, 3'b111);
    // R9 unused codes
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
    drive(32'h7FFF_FFFF, 32'h0000_0001, 3'b100);
    drive(32'hDEAD_BEEF, 32'h1357_9BDF, 3'b101);
    // random sweep over all codes
    for (int i = 0; i < 400; i++) begin
      drive($urandom, $urandom, 3'($urandom));
    end

    // R1: reset in mid-run overrides a pending add
    @(posedge clk); #1;
    @(negedge clk);
    rst = 1'b1; a = 32'hFFFF_FFFF; b = 32'd7; op = 3'b010;
    @(posedge clk); #1;
    check("R1", "mid reset result", result, '0);
    check("R1", "mid reset zero", {31'd0, zero}, 32'd1);
    check("R1", "mid reset carry", {31'd0, carry_out}, 32'd0);
    @(negedge clk); rst = 1'b0;
    drive(32'd3, 32'd4, 3'b010);
    @(posedge clk); #2;
    finish_run();
  end
endmodule